// File: doc/BRIEF.md
# Module Slot Window Decoder

This block sits behind a host access port on a carrier that holds up to four plug-in modules. Every host request names one of four windows: a register window, a 16-bit memory window, an 8-bit memory window, or a small configuration byte space. For the first three windows the block splits the address into a slot index, a target space and an offset. It checks that the addressed slot exists and holds a module. It then emits one registered downstream request a cycle later. The module side answers combinationally on `mod_rdata`, and the block returns a registered read response one cycle after that.

The register window and the 16-bit memory window each have a big-endian mode bit. When the bit is set, a byte access flips address bit 0 before decoding and a halfword access swaps its two data bytes. The swap applies both to write data going out and to read data coming back. The 8-bit memory window never does either. The mode bits live in the configuration byte space, which otherwise reads back a fixed computed pattern.

Requests that cannot be served are answered locally. An access to an empty slot returns zero on a read and is dropped on a write. An access size the window does not support returns zero and raises a sticky error flag.

Top module: `slot_window_decoder`

## Requirements
- R1: Register window (`req_win`=0): slot = address >> 8 and space = address bits [7:6]. Space 2 gives target ID (`dn_target`=1) with offset address & 0x3F. Space 3 gives target INT (`dn_target`=2) with offset address & 0x3F. Space 0 or 1 gives target IO (`dn_target`=0) with offset address & 0x7F.
- R2: 16-bit memory window (`req_win`=1): slot = address >> 23, `dn_target`=3, offset = address bits [22:0].
- R3: 8-bit memory window (`req_win`=2): slot = address >> 22, `dn_target`=4, offset = address bits [21:0]. It accepts byte size only and never alters the address or the data, whatever the mode bits hold.
- R4: When the window's big-endian bit is set, a byte access (`req_size`=0) to the register window or the 16-bit window is decoded from the address with bit 0 inverted.
- R5: When the window's big-endian bit is set, a halfword access (`req_size`=1) to the register window or the 16-bit window has its two data bytes exchanged. This applies to write data on `dn_wdata` and to read data on `rsp_rdata`. A byte access has no data swap.
- R6: Configuration window (`req_win`=3, byte size only). Reading byte a returns ((a*29+6) mod 256) & 0xFE for a < 128 and 0 otherwise, ORed in bit 0 with the mode bit stored at that byte. Mode bits sit in bit 0 of bytes 0x2B, 0x2F and 0x33. A write loads bit 0 of `req_wdata` into the bit of the addressed byte. The bit at 0x2F steers the register window, the bit at 0x33 steers the 16-bit window, and the bit at 0x2B is only stored. Writes to any other configuration byte change nothing. Configuration accesses are never forwarded downstream.
- R7: An access whose slot is 4 or above, or whose `slot_present` bit is 0, is not forwarded. A read of such a slot returns 0 and a write to it is dropped.
- R8: Sizes 2 and 3 on any window, and halfword size on the 8-bit or configuration window, are not forwarded. A read with such a size returns 0, and any such access sets `err_flag`, which stays set until reset.
- R9: An accepted request drives `dn_valid` and the decoded fields in the next cycle. Every read, forwarded or not, gets `rsp_valid` with `rsp_rdata` two cycles after the request. Writes get no response.
- R10: After reset `dn_valid`, `rsp_valid` and `err_flag` are 0 and all three mode bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | 0 register, 1 16-bit memory, 2 8-bit memory, 3 configuration |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 unsupported |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | 16 | Write data, byte accesses in bits [7:0] |
| slot_present | input | NSLOT | One bit per slot, 1 = module installed |
| dn_valid | output | 1 | Downstream request strobe |
| dn_write | output | 1 | Downstream write |
| dn_target | output | 3 | 0 IO, 1 ID, 2 INT, 3 16-bit memory, 4 8-bit memory |
| dn_slot | output | SLOT_W | Slot index |
| dn_offset | output | OFF_W | Offset within the target space |
| dn_size | output | 2 | Access size passed through |
| dn_wdata | output | 16 | Write data after lane swap |
| mod_rdata | input | 16 | Module read data, valid while dn_valid is high |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 16 | Read response data |
| err_flag | output | 1 | Sticky unsupported-size flag |

## Verification
A configuration write that flips a mode bit can share a cycle with an earlier read whose module data is still being swapped. The two must not interact: the swap decision is fixed when the read is accepted. The bench issues a halfword read in the 16-bit window and, in the very next cycle, a configuration write that sets that window's mode bit. The first response must arrive unswapped, and a repeat of the same read afterwards must arrive swapped. Both values are computed from the response model of the bench.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;
  // window codes on req_win
  localparam logic [1:0] WIN_REG = 2'd0;
  localparam logic [1:0] WIN_M16 = 2'd1;
  localparam logic [1:0] WIN_M8  = 2'd2;
  localparam logic [1:0] WIN_CFG = 2'd3;
  // access sizes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  // register window space field codes
  localparam logic [1:0] SPC_ID  = 2'd2;
  localparam logic [1:0] SPC_INT = 2'd3;
  // downstream target codes
  localparam logic [2:0] TGT_IO  = 3'd0;
  localparam logic [2:0] TGT_ID  = 3'd1;
  localparam logic [2:0] TGT_INT = 3'd2;
  localparam logic [2:0] TGT_M16 = 3'd3;
  localparam logic [2:0] TGT_M8  = 3'd4;
endpackage

// File: rtl/swd_lane_swap.sv
`timescale 1ns/1ps
module swd_lane_swap #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  // reverse byte order when enabled
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign dout[i*8 +: 8] = en ? din[(NB-1-i)*8 +: 8] : din[i*8 +: 8];
  end
endmodule

// File: rtl/swd_cfg_space.sv
`timescale 1ns/1ps
module swd_cfg_space #(
  parameter int ADDR_W    = 25,
  parameter int CFG_BYTES = 128,
  parameter int NFLAG     = 3,
  parameter int FLAG_BASE = 'h2B,
  parameter int FLAG_STEP = 4,
  parameter int BASE_MUL  = 29,
  parameter int BASE_ADD  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  output logic [NFLAG-2:0]  steer,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] CFG_LIM = ADDR_W'(CFG_BYTES);
  localparam logic [7:0]        MUL8    = 8'(BASE_MUL);
  localparam logic [7:0]        ADD8    = 8'(BASE_ADD);

  logic [NFLAG-1:0] hit;
  logic [NFLAG-1:0] flag_ld;
  logic [NFLAG-1:0] flag_q;
  logic [7:0]       a8;
  logic [7:0]       base;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign hit[i]     = (addr == ADDR_W'(FLAG_BASE + i * FLAG_STEP));
    assign flag_ld[i] = wr_en & hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (flag_ld[i]) begin
        flag_q[i] <= wbit;
      end
    end
  end

  // lowest flag is stored only; the rest steer windows
  assign steer = flag_q[NFLAG-1:1];

  always_comb begin
    a8    = addr[7:0];
    base  = (addr < CFG_LIM) ? ((a8 * MUL8 + ADD8) & 8'hFE) : 8'h00;
    rdata = base | {7'b0, |(hit & flag_q)};
  end
endmodule

// File: rtl/swd_window_decode.sv
`timescale 1ns/1ps
module swd_window_decode
  import swd_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int ADDR_W    = 25,
  parameter int REG_SHIFT = 8,
  parameter int M16_SHIFT = 23,
  parameter int M8_SHIFT  = 22,
  localparam int SLOT_W   = $clog2(NSLOT),
  localparam int OFF_W    = M16_SHIFT
) (
  input  logic [1:0]        win,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              be_reg,
  input  logic              be_m16,
  input  logic [NSLOT-1:0]  present,
  output logic              size_ok,
  output logic              fwd,
  output logic              swap,
  output logic [2:0]        tgt,
  output logic [SLOT_W-1:0] slot,
  output logic [OFF_W-1:0]  off
);
  localparam int IO_W = REG_SHIFT - 1;
  localparam int SP_W = REG_SHIFT - 2;
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IO_MASK  = (ONE << IO_W) - ONE;
  localparam logic [ADDR_W-1:0] SP_MASK  = (ONE << SP_W) - ONE;
  localparam logic [ADDR_W-1:0] M16_MASK = (ONE << M16_SHIFT) - ONE;
  localparam logic [ADDR_W-1:0] M8_MASK  = (ONE << M8_SHIFT) - ONE;
  localparam logic [ADDR_W-1:0] NSLOT_A  = ADDR_W'(NSLOT);

  logic              be_win;
  logic              flip;
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] slot_num;
  logic [1:0]        spc;

  always_comb begin
    be_win   = ((win == WIN_REG) && be_reg) || ((win == WIN_M16) && be_m16);
    flip     = be_win && (size == SZ_BYTE);
    swap     = be_win && (size == SZ_HALF);
    ea       = addr ^ ADDR_W'(flip);
    spc      = ea[REG_SHIFT-1 -: 2];
    slot_num = '0;
    tgt      = TGT_IO;
    off      = '0;
    case (win)
      WIN_REG: begin
        slot_num = ea >> REG_SHIFT;
        if (spc == SPC_ID) begin
          tgt = TGT_ID;
          off = OFF_W'(ea & SP_MASK);
        end else if (spc == SPC_INT) begin
          tgt = TGT_INT;
          off = OFF_W'(ea & SP_MASK);
        end else begin
          tgt = TGT_IO;
          off = OFF_W'(ea & IO_MASK);
        end
      end
      WIN_M16: begin
        slot_num = ea >> M16_SHIFT;
        tgt      = TGT_M16;
        off      = OFF_W'(ea & M16_MASK);
      end
      WIN_M8: begin
        slot_num = ea >> M8_SHIFT;
        tgt      = TGT_M8;
        off      = OFF_W'(ea & M8_MASK);
      end
      default: ;
    endcase
    size_ok = (size == SZ_BYTE) ||
              ((size == SZ_HALF) && ((win == WIN_REG) || (win == WIN_M16)));
    fwd     = size_ok && (win != WIN_CFG) && (slot_num < NSLOT_A) &&
              present[slot_num[SLOT_W-1:0]];
    slot    = slot_num[SLOT_W-1:0];
  end
endmodule

// File: rtl/slot_window_decoder.sv
`timescale 1ns/1ps
module slot_window_decoder
  import swd_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int ADDR_W    = 25,
  parameter int REG_SHIFT = 8,
  parameter int M16_SHIFT = 23,
  parameter int M8_SHIFT  = 22,
  parameter int CFG_BYTES = 128,
  localparam int SLOT_W   = $clog2(NSLOT),
  localparam int OFF_W    = M16_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_win,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [NSLOT-1:0]  slot_present,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [2:0]        dn_target,
  output logic [SLOT_W-1:0] dn_slot,
  output logic [OFF_W-1:0]  dn_offset,
  output logic [1:0]        dn_size,
  output logic [15:0]       dn_wdata,
  input  logic [15:0]       mod_rdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              err_flag
);
  // reset: asserted asynchronously, released on the clock (R10)
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // decode and configuration space
  logic              size_ok, fwd, swap_d;
  logic [2:0]        tgt_d;
  logic [SLOT_W-1:0] slot_d;
  logic [OFF_W-1:0]  off_d;
  logic [1:0]        steer;
  logic [7:0]        cfg_rdata;
  logic              cfg_wr;
  logic [15:0]       wdata_sw, rdata_sw;

  assign cfg_wr = req_valid && req_write && (req_win == WIN_CFG) && (req_size == SZ_BYTE);

  swd_cfg_space #(
    .ADDR_W(ADDR_W), .CFG_BYTES(CFG_BYTES), .NFLAG(3), .FLAG_BASE('h2B),
    .FLAG_STEP(4), .BASE_MUL(29), .BASE_ADD(6)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(cfg_wr), .addr(req_addr),
    .wbit(req_wdata[0]), .steer(steer), .rdata(cfg_rdata)
  );

  swd_window_decode #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT),
    .M16_SHIFT(M16_SHIFT), .M8_SHIFT(M8_SHIFT)
  ) u_dec (
    .win(req_win), .size(req_size), .addr(req_addr), .be_reg(steer[0]),
    .be_m16(steer[1]), .present(slot_present), .size_ok(size_ok), .fwd(fwd),
    .swap(swap_d), .tgt(tgt_d), .slot(slot_d), .off(off_d)
  );

  swd_lane_swap #(.W(16)) u_wswap (.en(swap_d), .din(req_wdata), .dout(wdata_sw));

  // stage 1 state
  logic       rd_pend_q, rd_fwd_q, rd_cfg_q, rd_swap_q, err_q;
  logic [7:0] rd_cfg_data_q;
  logic       dn_valid_d, rd_pend_d, rd_fwd_d, rd_cfg_d, err_d, s1_ld;

  always_comb begin
    s1_ld      = req_valid;
    dn_valid_d = req_valid && fwd;
    rd_pend_d  = req_valid && !req_write;
    rd_fwd_d   = rd_pend_d && fwd;
    rd_cfg_d   = rd_pend_d && (req_win == WIN_CFG) && size_ok;
    err_d      = err_q || (req_valid && !size_ok);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      dn_valid  <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_fwd_q  <= 1'b0;
      rd_cfg_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      dn_valid  <= dn_valid_d;
      rd_pend_q <= rd_pend_d;
      rd_fwd_q  <= rd_fwd_d;
      rd_cfg_q  <= rd_cfg_d;
      err_q     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      dn_write      <= 1'b0;
      dn_target     <= TGT_IO;
      dn_slot       <= '0;
      dn_offset     <= '0;
      dn_size       <= SZ_BYTE;
      dn_wdata      <= '0;
      rd_swap_q     <= 1'b0;
      rd_cfg_data_q <= '0;
    end else if (s1_ld) begin
      dn_write      <= req_write;
      dn_target     <= tgt_d;
      dn_slot       <= slot_d;
      dn_offset     <= off_d;
      dn_size       <= req_size;
      dn_wdata      <= wdata_sw;
      rd_swap_q     <= swap_d;   // swap decided at acceptance time
      rd_cfg_data_q <= cfg_rdata;
    end
  end

  assign err_flag = err_q;

  // stage 2: read response
  swd_lane_swap #(.W(16)) u_rswap (.en(rd_swap_q), .din(mod_rdata), .dout(rdata_sw));

  logic [15:0] rsp_data_d;
  always_comb begin
    if (rd_fwd_q)      rsp_data_d = rdata_sw;
    else if (rd_cfg_q) rsp_data_d = {8'h00, rd_cfg_data_q};
    else               rsp_data_d = 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_pend_q;
      if (rd_pend_q) rsp_rdata <= rsp_data_d;
    end
  end
endmodule

// File: rtl/swd_checker.sv
`timescale 1ns/1ps
module swd_checker #(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_win,
  input logic [1:0]        req_size,
  input logic [NSLOT-1:0]  slot_present,
  input logic              dn_valid,
  input logic              dn_write,
  input logic [2:0]        dn_target,
  input logic [SLOT_W-1:0] dn_slot,
  input logic [1:0]        dn_size,
  input logic              rsp_valid,
  input logic              err_flag
);
  logic bad_size;
  assign bad_size = req_size[1] || ((req_size == 2'd1) && req_win[1]);

  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && bad_size |=> err_flag && !dn_valid);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_m8_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && (dn_target == 3'd4) |-> dn_size == 2'd0);

  p_cfg_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_win == 2'd3) |=> !dn_valid);

  p_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> slot_present[dn_slot]);

  p_rd_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_write |=> rsp_valid);

  p_wr_norsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_write |=> !rsp_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dn_valid);
endmodule

bind slot_window_decoder swd_checker #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_swd_chk (
  .clk(clk), .rst_n(rst_sync_q), .req_valid(req_valid), .req_win(req_win),
  .req_size(req_size), .slot_present(slot_present), .dn_valid(dn_valid),
  .dn_write(dn_write), .dn_target(dn_target), .dn_slot(dn_slot),
  .dn_size(dn_size), .rsp_valid(rsp_valid), .err_flag(err_flag)
);

// File: tb/slot_window_decoder_tb_top.sv
`timescale 1ns/1ps
module slot_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_win, req_size;
  logic [24:0] req_addr;
  logic [15:0] req_wdata;
  logic [3:0]  slot_present;
  logic        dn_valid, dn_write;
  logic [2:0]  dn_target;
  logic [1:0]  dn_slot;
  logic [22:0] dn_offset;
  logic [1:0]  dn_size;
  logic [15:0] dn_wdata, mod_rdata, rsp_rdata;
  logic        rsp_valid, err_flag;

  int n_tests = 0;
  int n_fail  = 0;
  logic [2:0] be;        // model of mode bits: [0]@0x2B [1]@0x2F [2]@0x33
  logic       exp_err;

  always #2.5 clk = ~clk;

  slot_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_win(req_win), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .slot_present(slot_present), .dn_valid(dn_valid),
    .dn_write(dn_write), .dn_target(dn_target), .dn_slot(dn_slot),
    .dn_offset(dn_offset), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .mod_rdata(mod_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_flag(err_flag)
  );

  // module response model
  function automatic logic [15:0] mdl(input logic [1:0] s, input logic [2:0] t,
                                      input logic [22:0] o);
    return {s, t, o[10:0]};
  endfunction
  always_comb mod_rdata = mdl(dn_slot, dn_target, dn_offset);

  function automatic logic [7:0] cfgval(input logic [24:0] a);
    logic [7:0] v;
    if (a >= 25'd128) return 8'h00;
    v = (a[7:0] * 8'd29 + 8'd6) & 8'hFE;
    if (a == 25'h2B) v[0] = be[0];
    if (a == 25'h2F) v[0] = be[1];
    if (a == 25'h33) v[0] = be[2];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [1:0] w, input logic wr, input logic [1:0] sz,
                      input logic [24:0] a, input logic [15:0] wd, input string tag);
    logic bad, flip, swp, pres, fwd;
    logic [24:0] ea;
    logic [1:0]  sp;
    int unsigned sn;
    logic [2:0]  tgt;
    logic [22:0] off;
    logic [15:0] ewd, m, erd;
    bad  = sz[1] || (sz == 2'd1 && (w == 2'd2 || w == 2'd3));
    flip = sz == 2'd0 && ((w == 2'd0 && be[1]) || (w == 2'd1 && be[2]));
    swp  = sz == 2'd1 && ((w == 2'd0 && be[1]) || (w == 2'd1 && be[2]));
    ea   = a ^ {24'd0, flip};
    sp   = ea[7:6];
    case (w)
      2'd0: begin
        sn  = 32'(ea >> 8);
        tgt = (sp == 2'd2) ? 3'd1 : (sp == 2'd3) ? 3'd2 : 3'd0;
        off = (tgt == 3'd0) ? 23'(ea & 25'h7F) : 23'(ea & 25'h3F);
      end
      2'd1: begin sn = 32'(ea >> 23); tgt = 3'd3; off = ea[22:0]; end
      2'd2: begin sn = 32'(ea >> 22); tgt = 3'd4; off = {1'b0, ea[21:0]}; end
      default: begin sn = 99; tgt = 3'd0; off = '0; end
    endcase
    pres = (sn < 4) && slot_present[sn[1:0]];
    fwd  = !bad && (w != 2'd3) && pres;
    ewd  = swp ? {wd[7:0], wd[15:8]} : wd;
    m    = mdl(sn[1:0], tgt, off);
    if (fwd)                    erd = swp ? {m[7:0], m[15:8]} : m;
    else if (w == 2'd3 && !bad) erd = {8'h00, cfgval(a)};
    else                        erd = 16'h0000;
    if (bad) exp_err = 1'b1;

    req_valid = 1'b1; req_write = wr; req_win = w; req_size = sz;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (w == 2'd3 && wr && !bad) begin
      if (a == 25'h2B) be[0] = wd[0];
      if (a == 25'h2F) be[1] = wd[0];
      if (a == 25'h33) be[2] = wd[0];
    end
    chk({tag, " dn_valid"}, 32'(dn_valid), 32'(fwd));
    if (fwd) begin
      chk({tag, " dn_write"},  32'(dn_write), 32'(wr));
      chk({tag, " dn_target"}, 32'(dn_target), 32'(tgt));
      chk({tag, " dn_slot"},   32'(dn_slot), sn);
      chk({tag, " dn_offset"}, 32'(dn_offset), 32'(off));
      chk({tag, " dn_size"},   32'(dn_size), 32'(sz));
      if (wr) chk({tag, " dn_wdata"}, 32'(dn_wdata), 32'(ewd));
    end
    @(negedge clk);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'(!wr));
    if (!wr) chk({tag, " rsp_rdata"}, 32'(rsp_rdata), 32'(erd));
    chk({tag, " err_flag R8"}, 32'(err_flag), 32'(exp_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [22:0] offs16 [4];
    logic [5:0]  offs_r [4];
    offs16 = '{23'h0, 23'h1, 23'h7FFFFE, 23'h123457};
    offs_r = '{6'h00, 6'h01, 6'h15, 6'h3F};
    be = '0; exp_err = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_win = '0;
    req_size = '0; req_addr = '0; req_wdata = '0; slot_present = 4'b1011;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 dn_valid", 32'(dn_valid), 0);
    chk("R10 rsp_valid", 32'(rsp_valid), 0);
    chk("R10 err_flag", 32'(err_flag), 0);
    xact(2'd3, 1'b0, 2'd0, 25'h2B, 16'h0, "R10 flag 0x2B");
    xact(2'd3, 1'b0, 2'd0, 25'h2F, 16'h0, "R10 flag 0x2F");
    xact(2'd3, 1'b0, 2'd0, 25'h33, 16'h0, "R10 flag 0x33");

    // R1/R4/R5/R7: register window sweep, both endian modes
    for (int e = 0; e < 2; e++) begin
      xact(2'd3, 1'b1, 2'd0, 25'h2F, 16'(e), "R6 set reg mode");
      for (int s = 0; s < 5; s++)
        for (int sp = 0; sp < 4; sp++)
          for (int o = 0; o < 4; o++)
            for (int sz = 0; sz < 2; sz++)
              for (int wr = 0; wr < 2; wr++)
                xact(2'd0, 1'(wr), 2'(sz),
                     25'((s << 8) | (sp << 6) | int'(offs_r[o])),
                     16'hA51C ^ 16'(s * 7 + o), "R1/R4/R5/R7 regwin");
    end

    // R2/R4/R5/R7: 16-bit window sweep
    for (int e = 0; e < 2; e++) begin
      xact(2'd3, 1'b1, 2'd0, 25'h33, 16'(e), "R6 set m16 mode");
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          for (int sz = 0; sz < 2; sz++)
            for (int wr = 0; wr < 2; wr++)
              xact(2'd1, 1'(wr), 2'(sz), 25'((s << 23) | int'(offs16[o])),
                   16'h3C96 + 16'(o), "R2/R4/R5/R7 m16win");
    end

    // R3: 8-bit window, mode bits all set, no address or data change
    xact(2'd3, 1'b1, 2'd0, 25'h2B, 16'h1, "R6 set 0x2B");
    xact(2'd3, 1'b1, 2'd0, 25'h2F, 16'h1, "R6 set 0x2F");
    for (int s = 0; s < 8; s++)
      for (int o = 0; o < 3; o++)
        for (int wr = 0; wr < 2; wr++)
          xact(2'd2, 1'(wr), 2'd0,
               25'((s << 22) | ((o == 2) ? 'h3FFFFF : o)), 16'hBEEF, "R3/R7 m8win");

    // R6: configuration space read sweep and ignored writes
    for (int a = 0; a < 144; a++) xact(2'd3, 1'b0, 2'd0, 25'(a), 16'h0, "R6 cfg read");
    for (int a = 40; a < 56; a++)
      if (a != 'h2B && a != 'h2F && a != 'h33)
        xact(2'd3, 1'b1, 2'd0, 25'(a), 16'hFFFE, "R6 cfg ignored write");
    for (int a = 40; a < 56; a++) xact(2'd3, 1'b0, 2'd0, 25'(a), 16'h0, "R6 cfg readback");
    xact(2'd3, 1'b1, 2'd0, 25'h2B, 16'h0, "R6 clear 0x2B");
    xact(2'd3, 1'b0, 2'd0, 25'h2B, 16'h0, "R6 read 0x2B");

    // R9/R5: read in flight while a config write flips the 16-bit mode bit
    xact(2'd3, 1'b1, 2'd0, 25'h33, 16'h0, "R6 clear m16 mode");
    req_valid = 1'b1; req_write = 1'b0; req_win = 2'd1; req_size = 2'd1;
    req_addr = 25'((1 << 23) | 'h10); req_wdata = 16'h0;
    @(negedge clk);
    req_write = 1'b1; req_win = 2'd3; req_size = 2'd0; req_addr = 25'h33; req_wdata = 16'h1;
    chk("R9 overlap dn_valid", 32'(dn_valid), 1);
    @(negedge clk);
    req_valid = 1'b0;
    be[2] = 1'b1;
    chk("R9 overlap no fwd of cfg", 32'(dn_valid), 0);
    chk("R9 overlap rsp_valid", 32'(rsp_valid), 1);
    chk("R5 overlap old swap", 32'(rsp_rdata), 32'(mdl(2'd1, 3'd3, 23'h10)));
    @(negedge clk);
    chk("R9 write no rsp", 32'(rsp_valid), 0);
    xact(2'd1, 1'b0, 2'd1, 25'((1 << 23) | 'h10), 16'h0, "R5 new swap");

    // R8: unsupported sizes on every window
    for (int w = 0; w < 4; w++)
      for (int sz = 1; sz < 4; sz++)
        for (int wr = 0; wr < 2; wr++)
          xact(2'(w), 1'(wr), 2'(sz), 25'h1, 16'h1234, "R8 bad size");
    xact(2'd0, 1'b0, 2'd0, 25'h5, 16'h0, "R8 sticky after good access");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule